// File: doc/BRIEF.md
# Prioritised Chip-Select Decoder for a Split Code/Data Bus

This block drives the chip selects of three memory regions on an 8-bit controller bus. The bus has two separate address spaces. An active-low program-fetch strobe marks code accesses, and active-low read and write strobes mark data accesses. The three regions are a RAM/peripheral region, a secondary (boot) flash and a main flash. Each region owns a window made of a base register and a mask register. An address hits a window when every address bit whose mask bit is 1 equals the matching base bit. Windows may overlap. In that case a fixed order grants the region: RAM/peripheral first, then boot flash, then main flash.

A mapping byte, which the CPU can rewrite, sets whether each region answers code fetches, data accesses or both. The RAM/peripheral region always answers data accesses. All configuration registers take their reset values from parameters. New values go first into a pending copy. The copy that drives the decode picks them up only on a clock edge where no strobe is active, so a bus cycle that is already running never sees its mapping change.

Top module: `msel_decoder`

## Requirements
- R1: After reset the mapping byte reads back as the parameter `MAP_RST` with bits 7..5 forced to 0. The configuration port is at address 0 for the mapping byte and at `1+2*i` / `2+2*i` for the base / mask of region i.
- R2: A region hits when `(bus_addr & mask) == (base & mask)`.
- R3: `sel_o` is one-hot or zero. Index 0 is RAM/peripheral, 1 is boot flash and 2 is main flash. When several enabled regions hit, the lowest index wins.
- R4: A cycle is a code cycle when `prog_n` is low. Mapping bits 0, 1 and 2 enable RAM, boot flash and main flash for code cycles; a 0 bit blocks that region.
- R5: A cycle is a data read when `rd_n` is low and `prog_n` is high. RAM always answers data reads. Mapping bit 3 enables boot flash and bit 4 enables main flash.
- R6: A cycle is a data write when `wr_n` is low and both other strobes are high. The enables are the same as for a data read.
- R7: A region that hits but is blocked for the active strobe does not hide a lower-priority region that hits and is enabled.
- R8: With all strobes high, `sel_o` is 0.
- R9: A configuration write lands in a pending copy. The pending copy reaches the decode on the first clock edge at which all strobes are high, and never while a strobe is held low.
- R10: Mapping bits 7..5 always read back 0, whatever was written.
- R11: After reset the base and mask registers read back the parameters `BASE_RST` and `MASK_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| prog_n | input | 1 | Program-fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Pending value of the register at cfg_addr |
| sel_o | output | 3 | Region selects, one-hot or zero |

## Verification
The assertions assume that at most one strobe is low at a time. They also assume the address is steady within a clock period. The gating checks assume that a code cycle takes precedence if strobes ever overlap. The random stimulus picks exactly one kind of cycle per clock (idle, fetch, read or write) and drives all inputs at the falling edge. Configuration writes are mixed in both during idle clocks and while a strobe is held, so the deferred hand-over is exercised from both sides.

// File: rtl/msel_pkg.sv
package msel_pkg;

    localparam int NREG   = 3;
    localparam int CFG_AW = 3;
    localparam logic [7:0] MAP_USED = 8'h1F;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_CODE,
        CYC_DRD,
        CYC_DWR
    } cyc_e;

    typedef struct packed {
        logic [2:0] spare;
        logic       d_main;
        logic       d_boot;
        logic       c_main;
        logic       c_boot;
        logic       c_sram;
    } map_t;

    function automatic cyc_e cyc_decode(input logic prog_n, input logic rd_n,
                                        input logic wr_n);
        if (!prog_n)     return CYC_CODE;
        else if (!rd_n)  return CYC_DRD;
        else if (!wr_n)  return CYC_DWR;
        else             return CYC_IDLE;
    endfunction

    function automatic logic [NREG-1:0] cyc_enable(input cyc_e k, input map_t m);
        case (k)
            CYC_CODE:         return {m.c_main, m.c_boot, m.c_sram};
            CYC_DRD, CYC_DWR: return {m.d_main, m.d_boot, 1'b1};
            default:          return '0;
        endcase
    endfunction

endpackage

// File: rtl/msel_cfg_regs.sv
module msel_cfg_regs
    import msel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [7:0] MAP_RST = 8'h12,
    parameter logic [NREG-1:0][ADDR_W-1:0] BASE_RST = '0,
    parameter logic [NREG-1:0][ADDR_W-1:0] MASK_RST = '0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           idle,
    input  logic                           we,
    input  logic [CFG_AW-1:0]              addr,
    input  logic [ADDR_W-1:0]              wdata,
    output logic [ADDR_W-1:0]              rdata,
    output map_t                           act_map,
    output logic [NREG-1:0][ADDR_W-1:0]    act_base,
    output logic [NREG-1:0][ADDR_W-1:0]    act_mask
);

    localparam map_t MAP_INIT = map_t'(MAP_RST & MAP_USED);

    map_t                        pend_map;
    logic [NREG-1:0][ADDR_W-1:0] pend_base;
    logic [NREG-1:0][ADDR_W-1:0] pend_mask;

    // Pending copy: written by the CPU at any time
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_map  <= MAP_INIT;
            pend_base <= BASE_RST;
            pend_mask <= MASK_RST;
        end else if (we) begin
            if (addr == '0)
                pend_map <= map_t'(wdata[7:0] & MAP_USED);
            for (int i = 0; i < NREG; i++) begin
                if (addr == CFG_AW'(1 + 2*i)) pend_base[i] <= wdata;
                if (addr == CFG_AW'(2 + 2*i)) pend_mask[i] <= wdata;
            end
        end
    end

    // Active copy: follows the pending one only between bus cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            act_map  <= MAP_INIT;
            act_base <= BASE_RST;
            act_mask <= MASK_RST;
        end else if (idle) begin
            act_map  <= pend_map;
            act_base <= pend_base;
            act_mask <= pend_mask;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == '0)
            rdata[7:0] = pend_map;
        for (int i = 0; i < NREG; i++) begin
            if (addr == CFG_AW'(1 + 2*i)) rdata = pend_base[i];
            if (addr == CFG_AW'(2 + 2*i)) rdata = pend_mask[i];
        end
    end

endmodule

// File: rtl/msel_window.sv
module msel_window #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    assign hit = ((addr ^ base) & mask) == '0;
endmodule

// File: rtl/msel_prio.sv
module msel_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;
    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msel_decoder.sv
module msel_decoder
    import msel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [7:0] MAP_RST = 8'h12,
    parameter logic [NREG-1:0][ADDR_W-1:0] BASE_RST = {16'h0000, 16'h8000, 16'h0000},
    parameter logic [NREG-1:0][ADDR_W-1:0] MASK_RST = {16'h0000, 16'hC000, 16'hE000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              prog_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic [2:0]        sel_o
);

    cyc_e                        cyc;
    logic                        idle;
    map_t                        act_map;
    logic [NREG-1:0][ADDR_W-1:0] act_base;
    logic [NREG-1:0][ADDR_W-1:0] act_mask;
    logic [NREG-1:0]             hit;
    logic [NREG-1:0]             en;
    logic [NREG-1:0]             req;

    assign cyc  = cyc_decode(prog_n, rd_n, wr_n);
    assign idle = (cyc == CYC_IDLE);

    msel_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .MAP_RST  (MAP_RST),
        .BASE_RST (BASE_RST),
        .MASK_RST (MASK_RST)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .idle     (idle),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .act_map  (act_map),
        .act_base (act_base),
        .act_mask (act_mask)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_win
        msel_window #(.ADDR_W(ADDR_W)) u_win (
            .addr (bus_addr),
            .base (act_base[g]),
            .mask (act_mask[g]),
            .hit  (hit[g])
        );
    end

    // Gate before arbitration so a blocked region never shadows a lower one
    assign en  = cyc_enable(cyc, act_map);
    assign req = hit & en;

    msel_prio #(.N(NREG)) u_prio (
        .req (req),
        .gnt (sel_o)
    );

endmodule

// File: rtl/msel_decoder_chk.sv
module msel_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       prog_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [2:0] sel_o,
    input logic [7:0] act_map
);
    logic past_ok;
    logic quiet;
    assign quiet = prog_n && rd_n && wr_n;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        quiet |-> (sel_o == 3'b000)); // R8
    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !quiet && !$past(quiet)) |-> $stable(act_map)); // R9
    AST_CODE_RAM_GATE: assert property (@(posedge clk) disable iff (rst)
        (!prog_n && sel_o[0]) |-> act_map[0]); // R4
    AST_READ_MAIN_GATE: assert property (@(posedge clk) disable iff (rst)
        (prog_n && !rd_n && sel_o[2]) |-> act_map[4]); // R5
    AST_WRITE_BOOT_GATE: assert property (@(posedge clk) disable iff (rst)
        (prog_n && rd_n && !wr_n && sel_o[1]) |-> act_map[3]); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        act_map[7:5] == 3'b000); // R10

endmodule

bind msel_decoder msel_decoder_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .prog_n  (prog_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .sel_o   (sel_o),
    .act_map (act_map)
);

// File: tb/sim_msel_decoder.sv
module sim_msel_decoder;

    localparam int AW = 16;
    localparam logic [7:0] MAPR = 8'hF2;
    localparam logic [2:0][15:0] BR = {16'h0000, 16'h8000, 16'h0000};
    localparam logic [2:0][15:0] MR = {16'h0000, 16'hC000, 16'hE000};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          prog_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic [2:0]    sel_o;

    int total = 0;
    int bad   = 0;

    // bench model: pending and active copies
    logic [7:0]  p_map, a_map;
    logic [15:0] p_base [3], p_mask [3], a_base [3], a_mask [3];

    always #4 clk = ~clk;

    msel_decoder #(.ADDR_W(AW), .MAP_RST(MAPR), .BASE_RST(BR), .MASK_RST(MR)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .prog_n(prog_n), .rd_n(rd_n),
        .wr_n(wr_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sel_o(sel_o));

    function automatic logic [2:0] exp_sel(input int kind, input logic [15:0] a);
        logic [2:0] en, req;
        case (kind)
            1:       en = a_map[2:0];
            2, 3:    en = {a_map[4], a_map[3], 1'b1};
            default: en = 3'b000;
        endcase
        for (int i = 0; i < 3; i++)
            req[i] = en[i] && (((a ^ a_base[i]) & a_mask[i]) == 16'h0);
        if (req[0]) return 3'b001;
        if (req[1]) return 3'b010;
        if (req[2]) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [2:0] ra);
        if (ra == 3'd0) return {8'h00, p_map};
        for (int i = 0; i < 3; i++) begin
            if (ra == 3'(1 + 2*i)) return p_base[i];
            if (ra == 3'(2 + 2*i)) return p_mask[i];
        end
        return 16'h0;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at falling edge, check, then advance model at rising edge
    task automatic cyc(input int kind, input logic [15:0] a, input logic we,
                       input logic [2:0] ra, input logic [15:0] wd, input string req);
        @(negedge clk);
        bus_addr = a;
        prog_n = (kind != 1); rd_n = (kind != 2); wr_n = (kind != 3);
        cfg_we = we; cfg_addr = ra; cfg_wdata = wd;
        #2;
        check(req, {13'h0, sel_o}, {13'h0, exp_sel(kind, a)});
        @(posedge clk);
        if (kind == 0) begin
            a_map = p_map;
            for (int i = 0; i < 3; i++) begin a_base[i] = p_base[i]; a_mask[i] = p_mask[i]; end
        end
        if (we) begin
            if (ra == 3'd0) p_map = wd[7:0] & 8'h1F;
            for (int i = 0; i < 3; i++) begin
                if (ra == 3'(1 + 2*i)) p_base[i] = wd;
                if (ra == 3'(2 + 2*i)) p_mask[i] = wd;
            end
        end
    endtask

    task automatic rdchk(input logic [2:0] ra, input string req);
        @(negedge clk);
        prog_n = 1; rd_n = 1; wr_n = 1; cfg_we = 0; cfg_addr = ra;
        #2;
        check(req, cfg_rdata, exp_rd(ra));
        @(posedge clk);
        a_map = p_map;
        for (int i = 0; i < 3; i++) begin a_base[i] = p_base[i]; a_mask[i] = p_mask[i]; end
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        p_map = MAPR & 8'h1F;
        for (int i = 0; i < 3; i++) begin p_base[i] = BR[i]; p_mask[i] = MR[i]; end
        a_map = p_map;
        for (int i = 0; i < 3; i++) begin a_base[i] = p_base[i]; a_mask[i] = p_mask[i]; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 / R11: reset readback (map expected 0x12)
        rdchk(3'd0, "R1");
        check("R1", cfg_rdata, 16'h0012);
        for (int r = 1; r < 7; r++) rdchk(3'(r), "R11");

        // directed decode with reset map 0x12
        cyc(0, 16'h0100, 0, 0, 0, "R8");           // idle: no select
        cyc(1, 16'h8100, 0, 0, 0, "R3");           // boot beats main in code space
        cyc(1, 16'h0100, 0, 0, 0, "R4");           // code to RAM blocked -> none
        cyc(0, 16'h0, 0, 0, 0, "R8");
        cyc(2, 16'h0100, 0, 0, 0, "R5");           // data read -> RAM
        cyc(2, 16'h8100, 0, 0, 0, "R7");           // boot blocked for data -> main
        cyc(3, 16'h0100, 0, 0, 0, "R6");           // data write -> RAM
        cyc(3, 16'h4000, 0, 0, 0, "R2");           // outside RAM/boot -> main

        // R10: unused bits masked
        cyc(0, 16'h0, 1, 3'd0, 16'h00FF, "R8");
        rdchk(3'd0, "R10");
        check("R10", cfg_rdata, 16'h001F);

        // R9: change during a held code strobe is deferred
        cyc(0, 16'h0, 1, 3'd0, 16'h0012, "R8");
        cyc(0, 16'h0, 0, 0, 0, "R8");
        cyc(1, 16'h0100, 1, 3'd0, 16'h0001, "R9");
        cyc(1, 16'h0100, 0, 0, 0, "R9");            // still old map: none
        check("R9", {13'h0, sel_o}, 16'h0000);
        cyc(0, 16'h0, 0, 0, 0, "R8");
        cyc(1, 16'h0100, 0, 0, 0, "R9");            // now RAM
        check("R9", {13'h0, sel_o}, 16'h0001);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int kind;
            logic we;
            kind = $urandom_range(0, 3);
            we = ($urandom_range(0, 9) == 0);
            cyc(kind, 16'($urandom), we, 3'($urandom_range(0, 6)), 16'($urandom), "R3");
        end
        for (int r = 0; r < 7; r++) rdchk(3'(r), "R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule